// File: doc/BRIEF.md
# Compensated Seconds Prescaler

The block turns a 32768 Hz clock-enable stream into a one-second tick for a timekeeping core. In normal running, each second lasts exactly a nominal number of enable pulses (32768 by default). The calendar counters sit outside this block. They report back two indications: the minute count is zero, and the second count is zero.

When auto-compensation is on and both indications are high, the second that starts at the top of the hour is trimmed. Its length is the nominal count plus a signed 16-bit compensation value, so crystal drift can be corrected once per hour. The compensation value lives in two byte-wide registers. The enable bit lives in a control register. All three are reached through a simple byte register port.

The length of each second is fixed at its first counted enable. A register write made while a second is running therefore only affects a later hourly second.

Top module: `cmp_sec_prescaler`

## Requirements
- R1: After synchronous reset, the compensation value is 0, auto-compensation is off, and `sec_tick` is low. Reads of control (0x40), compensation low (0x4C) and compensation high (0x50) return 0x00.
- R2: With compensation not applied, `sec_tick` pulses once every DIV_NOM enables (default 32768).
- R3: A write to offset 0x4C sets compensation bits 7:0, leaves bits 15:8 unchanged, and reads back at 0x4C.
- R4: A write to offset 0x50 sets compensation bits 15:8, leaves bits 7:0 unchanged, and reads back at 0x50.
- R5: When control bit 2 is clear, the compensation value has no effect on second length, even at the top of the hour.
- R6: With control bit 2 set, a second that starts while both `cal_min_zero` and `cal_sec_zero` are high lasts DIV_NOM + C enables. Here C is the compensation value read as two's complement, and it is positive in this case.
- R7: A negative C (bit 15 set) shortens that second by |C| enables.
- R8: If only one of the two calendar indications is high when a second starts, that second has the nominal length.
- R9: A compensation write made during a running second does not change that second's length. It takes effect at the next hourly second.
- R10: If DIV_NOM + C is below 1, the compensated second lasts exactly 1 enable.
- R11: `sec_tick` is a single-clock pulse. It is asserted in the clock after the enable that completes a second.
- R12: Only cycles with `ce_32k` high are counted. Idle cycles between enables do not change second length.
- R13: Control bit 2 reads back as written at 0x40. All other control bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_32k | input | 1 | 32768 Hz count enable, one clock wide |
| cal_min_zero | input | 1 | Calendar minutes equal zero |
| cal_sec_zero | input | 1 | Calendar seconds equal zero |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write offset |
| reg_wdata | input | 8 | Register write data |
| reg_re | input | 1 | Register read strobe |
| reg_raddr | input | 8 | Register read offset |
| reg_rdata | output | 8 | Registered read data, valid the clock after `reg_re` |
| sec_tick | output | 1 | One-second tick pulse |

## Verification
A register write takes effect at the next clock edge. Read data appears one clock after the read strobe, so the bench drives strobes on the falling edge and samples `reg_rdata` on the following falling edge. `sec_tick` rises one clock after the enable that ends a second. The bench counts the enables it issues, and on each falling edge looks for a tick produced by the enable issued the edge before. This gives the measured second length in enables, which is compared with the length computed from the flags, the control bit and the signed compensation value held at the start of that second.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h40;
  localparam logic [REG_AW-1:0] OFS_COMP_LO = 8'h4C;
  localparam logic [REG_AW-1:0] OFS_COMP_HI = 8'h50;
  localparam int unsigned CTRL_AUTO_BIT = 2;
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int unsigned COMP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [REG_AW-1:0] raddr,
  output logic [7:0]        rdata,
  output logic [COMP_W-1:0] comp,
  output logic              auto_en
);
  localparam int unsigned NBYTES = COMP_W / 8;

  logic [COMP_W-1:0] comp_q;
  logic              auto_q;
  logic [7:0]        rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      comp_q <= '0;
      auto_q <= 1'b0;
    end else if (we) begin
      if (waddr == OFS_CTRL) auto_q <= wdata[CTRL_AUTO_BIT];
      if (waddr == OFS_COMP_LO) comp_q[7:0] <= wdata;
      if (waddr == OFS_COMP_HI) comp_q[COMP_W-1:COMP_W-8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= 8'h00;
    else if (re) begin
      unique case (raddr)
        OFS_CTRL:    rdata_q <= 8'(auto_q) << CTRL_AUTO_BIT;
        OFS_COMP_LO: rdata_q <= comp_q[7:0];
        OFS_COMP_HI: rdata_q <= comp_q[COMP_W-1:COMP_W-8];
        default:     rdata_q <= 8'h00;
      endcase
    end
  end

  assign comp    = comp_q;
  assign auto_en = auto_q;
  assign rdata   = rdata_q;

  initial begin
    assert (NBYTES == 2) else $error("compensation must be two bytes");
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (comp_q == '0 && !auto_q && rdata_q == 8'h00));

  assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == OFS_COMP_LO) |=> comp_q[COMP_W-1:8] == $past(comp_q[COMP_W-1:8]));

  assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == OFS_COMP_HI) |=> comp_q[7:0] == $past(comp_q[7:0]));
endmodule

// File: rtl/cmp_len.sv
module cmp_len #(
  parameter int unsigned DIV_NOM = 32768,
  parameter int unsigned COMP_W  = 16,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic              min_zero,
  input  logic              sec_zero,
  input  logic [COMP_W-1:0] comp,
  output logic [CNT_W-1:0]  len_m1
);
  localparam int unsigned SW = CNT_W + 2;
  localparam logic signed [SW-1:0] NOM_S = SW'(DIV_NOM);
  localparam logic signed [SW-1:0] ONE_S = SW'(1);

  logic              hour_edge;
  logic signed [SW-1:0] comp_s;
  logic signed [SW-1:0] sum_s;
  logic signed [SW-1:0] len_s;
  logic signed [SW-1:0] lenm1_s;

  assign hour_edge = auto_en && min_zero && sec_zero;
  assign comp_s    = {{(SW-COMP_W){comp[COMP_W-1]}}, comp};
  assign sum_s     = NOM_S + comp_s;

  always_comb begin
    if (!hour_edge)        len_s = NOM_S;
    else if (sum_s < ONE_S) len_s = ONE_S;
    else                   len_s = sum_s;
  end

  assign lenm1_s = len_s - ONE_S;
  assign len_m1  = lenm1_s[CNT_W-1:0];

  assert_nominal_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !auto_en |-> (len_m1 == CNT_W'(DIV_NOM - 1)));

  assert_one_flag_nominal_R8: assert property (@(posedge clk) disable iff (rst)
    (min_zero != sec_zero) |-> (len_m1 == CNT_W'(DIV_NOM - 1)));
endmodule

// File: rtl/cmp_divider.sv
module cmp_divider #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [CNT_W-1:0] len_m1_new,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] term;
  logic             tick_q;
  logic             at_end;

  assign term   = (cnt_q == '0) ? len_m1_new : term_q;
  assign at_end = (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      term_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= ce && at_end;
      if (ce) begin
        if (cnt_q == '0) term_q <= len_m1_new;
        if (at_end) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick = tick_q;

  assert_tick_after_ce_R11: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(ce));

  assert_tick_single_R11: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q || $past(ce));

  assert_restart_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> (cnt_q == '0));

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q <= term_q));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_sec_prescaler.sv
module cmp_sec_prescaler
  import cmp_pkg::*;
#(
  parameter int unsigned DIV_NOM = 32768,
  parameter int unsigned COMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_32k,
  input  logic              cal_min_zero,
  input  logic              cal_sec_zero,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [7:0]        reg_rdata,
  output logic              sec_tick
);
  localparam int unsigned CNT_W = $clog2(DIV_NOM + 2**(COMP_W-1));

  logic [COMP_W-1:0] comp;
  logic              auto_en;
  logic [CNT_W-1:0]  len_m1;

  cmp_regs #(.COMP_W(COMP_W)) u_regs (
    .clk(clk), .rst(rst),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .re(reg_re), .raddr(reg_raddr), .rdata(reg_rdata),
    .comp(comp), .auto_en(auto_en)
  );

  cmp_len #(.DIV_NOM(DIV_NOM), .COMP_W(COMP_W), .CNT_W(CNT_W)) u_len (
    .clk(clk), .rst(rst),
    .auto_en(auto_en), .min_zero(cal_min_zero), .sec_zero(cal_sec_zero),
    .comp(comp), .len_m1(len_m1)
  );

  cmp_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .ce(ce_32k),
    .len_m1_new(len_m1), .tick(sec_tick)
  );
endmodule

// File: tb/cmp_sec_prescaler_tb.sv
module cmp_sec_prescaler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic mz = 1'b0, sz = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [7:0] waddr = 8'h00, wdata = 8'h00, raddr = 8'h00;
  logic [7:0] rdata;
  logic tick;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_sec_prescaler #(.DIV_NOM(NOM), .COMP_W(16)) u_dut (
    .clk(clk), .rst(rst), .ce_32k(ce),
    .cal_min_zero(mz), .cal_sec_zero(sz),
    .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_re(re), .reg_raddr(raddr), .reg_rdata(rdata),
    .sec_tick(tick)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input bit au, input bit m0, input bit s0, input int c);
    int l;
    if (!(au && m0 && s0)) return NOM;
    l = NOM + c;
    return (l < 1) ? 1 : l;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; raddr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic set_comp(input int c);
    logic [15:0] v;
    v = c[15:0];
    wr(8'h4C, v[7:0]);
    wr(8'h50, v[15:8]);
  endtask

  // Counts enables until the tick; optionally writes comp low byte mid-second.
  task automatic measure(input bit dense, input int wr_at, input logic [7:0] wv,
                         output int n, output bit pulse_ok);
    bit prev_tick;
    n = 0; pulse_ok = 1'b1; prev_tick = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      we = 1'b0;
      if (tick) begin ce = 1'b0; return; end
      if (wr_at >= 0 && n == wr_at) begin we = 1'b1; waddr = 8'h4C; wdata = wv; end
      ce = dense ? 1'b1 : (($urandom % 4) != 0);
      if (ce) n++;
    end
    ce = 1'b0;
    n = -1;
  endtask

  initial begin
    logic [7:0] d;
    int n;
    bit pok;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tick == 1'b0, "R1 tick low", int'(tick), 0);
    rd(8'h40, d); chk(d == 8'h00, "R1 ctrl", d, 0);
    rd(8'h4C, d); chk(d == 8'h00, "R1 comp lo", d, 0);
    rd(8'h50, d); chk(d == 8'h00, "R1 comp hi", d, 0);

    // R2 nominal, dense and sparse enables (R12)
    measure(1'b1, -1, 8'h00, n, pok); chk(n == NOM, "R2 dense", n, NOM);
    measure(1'b0, -1, 8'h00, n, pok); chk(n == NOM, "R12 sparse", n, NOM);

    // R11: tick lasts one clock when enables are idle after it
    mz = 1'b0; sz = 1'b0;
    measure(1'b1, -1, 8'h00, n, pok);
    @(negedge clk); chk(tick == 1'b0, "R11 single pulse", int'(tick), 0);

    // R3/R4 byte lanes
    wr(8'h50, 8'hA5); wr(8'h4C, 8'h5A);
    rd(8'h4C, d); chk(d == 8'h5A, "R3 lo readback", d, 8'h5A);
    rd(8'h50, d); chk(d == 8'hA5, "R3 hi kept", d, 8'hA5);
    wr(8'h50, 8'h3C);
    rd(8'h4C, d); chk(d == 8'h5A, "R4 lo kept", d, 8'h5A);
    rd(8'h50, d); chk(d == 8'h3C, "R4 hi readback", d, 8'h3C);

    // R13 control readback
    wr(8'h40, 8'hFF); rd(8'h40, d); chk(d == 8'h04, "R13 ctrl", d, 4);
    wr(8'h40, 8'h00); rd(8'h40, d); chk(d == 8'h00, "R13 ctrl clear", d, 0);

    // R5 auto off, hour boundary
    set_comp(20); mz = 1'b1; sz = 1'b1;
    measure(1'b0, -1, 8'h00, n, pok); chk(n == NOM, "R5 auto off", n, NOM);

    // R6 positive
    wr(8'h40, 8'h04);
    measure(1'b1, -1, 8'h00, n, pok); chk(n == NOM + 20, "R6 positive", n, NOM + 20);
    // R8 one flag only
    mz = 1'b1; sz = 1'b0;
    measure(1'b1, -1, 8'h00, n, pok); chk(n == NOM, "R8 min only", n, NOM);
    mz = 1'b0; sz = 1'b1;
    measure(1'b0, -1, 8'h00, n, pok); chk(n == NOM, "R8 sec only", n, NOM);

    // R7 negative
    set_comp(-17); mz = 1'b1; sz = 1'b1;
    measure(1'b0, -1, 8'h00, n, pok); chk(n == NOM - 17, "R7 negative", n, NOM - 17);

    // R9 mid-second write
    set_comp(10);
    measure(1'b1, 5, 8'h00, n, pok); chk(n == NOM + 10, "R9 current kept", n, NOM + 10);
    wr(8'h50, 8'h00);
    measure(1'b1, -1, 8'h00, n, pok); chk(n == NOM, "R9 next hour", n, NOM);

    // R10 clamp corners
    set_comp(-100);
    measure(1'b1, -1, 8'h00, n, pok); chk(n == 1, "R10 clamp", n, 1);
    set_comp(-63);
    measure(1'b0, -1, 8'h00, n, pok); chk(n == 1, "R10 exact one", n, 1);
    set_comp(-32768);
    measure(1'b1, -1, 8'h00, n, pok); chk(n == 1, "R10 most negative", n, 1);
    set_comp(-62);
    measure(1'b1, -1, 8'h00, n, pok); chk(n == 2, "R10 two", n, 2);

    // Random mix (R5..R8)
    for (int i = 0; i < 30; i++) begin
      int c, e;
      bit au;
      c  = int'($urandom % 81) - 40;
      au = $urandom % 2;
      set_comp(c);
      wr(8'h40, au ? 8'h04 : 8'h00);
      mz = ($urandom % 3) != 0;
      sz = ($urandom % 3) != 0;
      e = exp_len(au, mz, sz, c);
      measure(($urandom % 2) == 1, -1, 8'h00, n, pok);
      chk(n == e, "R6/R7 random", n, e);
    end

    finish_run();
  end
endmodule